// File: doc/BRIEF.md
# Byte-Wide SPI Master with Mode-Fault Handling

This block moves one byte at a time over a four-wire serial link as the link master. Software writes a byte into a transmit holding register over a simple register bus. The engine copies that byte into its shift register and drives a serial clock whose rate comes from a two-field prescaler. It shifts the byte out most significant bit first and collects the byte returned on the input line. When the eighth bit is in, it copies the received byte into a read register.

Three flags report progress:
- a receive-complete flag;
- a transmit-empty flag;
- a mode-fault flag, set when another device pulls the select input low while this block owns the link.

Each flag clears only through a two-step access sequence. A first access reads the status register and sees the flag set. A second access then touches the data register or control register 1.

A detected mode fault makes the block give up the link at once. It stops driving the clock and data outputs, abandons the byte in flight and clears its own master bit. An interrupt line combines the flags under two enable bits.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the status register reads 0x20, the clock and data output enables are 0, the select output is 1, the interrupt is 0 and control register 1 (address 0) reads 0.
- R2: The status register (address 3) has the receive-complete flag at bit 7, the transmit-empty flag at bit 5 and the mode-fault flag at bit 4. All other bits read 0, and a write to address 3 changes nothing.
- R3: The baud register (address 2) holds a prescale field in bits 6:4 and a rate field in bits 2:0. The serial clock period is (prescale+1)·2^(rate+1) bus clocks.
- R4: A transfer shifts the transmit byte out MSB first and samples the input line on the leading clock edge, with data changing on the trailing edge. The received byte reads back from the data register (address 5). The select output is low only while a transfer runs.
- R5: The receive-complete flag sets when a transfer ends. It clears on a data read only if a status read that saw it set came earlier. A data read with no such status read leaves it set.
- R6: A data write is accepted only after a status read that saw the transmit-empty flag set. An accepted write clears the flag, and the flag sets again once the byte moves to the shifter. A data write without that status read is ignored and starts no transfer.
- R7: The mode-fault flag sets when the select input is low while the block is enabled (control 1 bit 6), is master (control 1 bit 4) and has fault detection on (control 2 bit 4). With detection off, a low select input has no effect.
- R8: On a mode fault the block clears its master bit, drops both output enables, raises the select output and abandons the transfer without setting the receive-complete flag.
- R9: The mode-fault flag clears on a write to control register 1 only if a status read that saw it set came earlier. A control write without that read leaves it set.
- R10: The interrupt is high when control 1 bit 7 is set and either the receive-complete or the mode-fault flag is set, or when control 1 bit 5 is set and the transmit-empty flag is set.
- R11: Control 1 bit 3 sets the idle clock level. With it set, the clock idles high and the leading edge is falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Select input watched for mode faults |
| ss_n_o | output | 1 | Select output, low during a transfer |

## Verification
The hardest case to reach is a mode fault that lands in the middle of a byte. The stimulus must also show that the fault flag survives a control write that had no status read before it. The bench starts a transfer at the slowest divisor and pulls the select input low a few hundred cycles in. It then reads control register 1 without touching the status register and writes it back. It waits past the point where the byte would have ended, confirms that no receive-complete flag appeared, and only then performs the proper read-then-write release. The ignored data write is checked in the same careful way: it is issued before the very first status read, so that no earlier access has already armed the handshake.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BUS_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL2 = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BAUD  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd5;

  // control register 1 bit positions
  localparam int C1_RXIE = 7;
  localparam int C1_EN   = 6;
  localparam int C1_TXIE = 5;
  localparam int C1_MSTR = 4;
  localparam int C1_CPOL = 3;
  // control register 2
  localparam int C2_FEN  = 4;
  // status register
  localparam int ST_RXF  = 7;
  localparam int ST_TXE  = 5;
  localparam int ST_FLT  = 4;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_LEAD  = 2'd1,
    SH_TRAIL = 2'd2
  } shift_state_e;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = PRE_W + (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;

  always_comb begin
    half_m1 = ((CNT_W'(pre) + CNT_W'(1)) << rate) - CNT_W'(1);
    tick    = run && (cnt_q == half_m1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpol,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  shift_state_e      st_q, st_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              sck_q, sck_d, done_q, done_d;

  always_comb begin
    st_d   = st_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        sck_d = cpol;
        if (start) begin
          tx_d  = tx_byte;
          bit_d = '0;
          st_d  = SH_LEAD;
        end
      end
      SH_LEAD: if (tick) begin
        sck_d = ~cpol;
        rx_d  = {rx_q[DATA_W-2:0], miso};
        st_d  = SH_TRAIL;
      end
      SH_TRAIL: if (tick) begin
        sck_d = cpol;
        if (bit_q == LAST_BIT) begin
          st_d   = SH_IDLE;
          done_d = 1'b1;
        end else begin
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
          bit_d = bit_q + BIT_W'(1);
          st_d  = SH_LEAD;
        end
      end
      default: st_d = SH_IDLE;
    endcase
    if (abort) begin
      st_d   = SH_IDLE;
      sck_d  = cpol;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      sck_q  <= sck_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q != SH_IDLE);
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign mosi    = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic ctrl1_wr,
  input  logic xfer_done,
  input  logic buf_load,
  input  logic fault,
  output logic spif,
  output logic sptef,
  output logic modf,
  output logic tx_accept
);
  logic rxf_q, rxf_d, txe_q, txe_d, flt_q, flt_d;
  logic arm_rx_q, arm_rx_d, arm_tx_q, arm_tx_d, arm_ft_q, arm_ft_d;
  logic rx_clr, ft_clr;

  always_comb begin
    rx_clr    = arm_rx_q && data_rd;
    tx_accept = arm_tx_q && txe_q && data_wr;
    ft_clr    = arm_ft_q && ctrl1_wr;

    rxf_d = rxf_q;
    if (rx_clr)    rxf_d = 1'b0;
    if (xfer_done) rxf_d = 1'b1;

    txe_d = txe_q;
    if (tx_accept) txe_d = 1'b0;
    if (buf_load)  txe_d = 1'b1;

    flt_d = flt_q;
    if (ft_clr) flt_d = 1'b0;
    if (fault)  flt_d = 1'b1;

    arm_rx_d = stat_rd ? rxf_q : (rx_clr    ? 1'b0 : arm_rx_q);
    arm_tx_d = stat_rd ? txe_q : (tx_accept ? 1'b0 : arm_tx_q);
    arm_ft_d = stat_rd ? flt_q : (ft_clr    ? 1'b0 : arm_ft_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q    <= 1'b0;
      txe_q    <= 1'b1;
      flt_q    <= 1'b0;
      arm_rx_q <= 1'b0;
      arm_tx_q <= 1'b0;
      arm_ft_q <= 1'b0;
    end else begin
      rxf_q    <= rxf_d;
      txe_q    <= txe_d;
      flt_q    <= flt_d;
      arm_rx_q <= arm_rx_d;
      arm_tx_q <= arm_tx_d;
      arm_ft_q <= arm_ft_d;
    end
  end

  assign spif  = rxf_q;
  assign sptef = txe_q;
  assign modf  = flt_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  input  logic              ss_n_i,
  output logic              ss_n_o
);
  localparam int PRE_LSB = RATE_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic rxie_q, en_q, txie_q, mstr_q, cpol_q, ctrl2_fen_q;
  logic rxie_d, en_d, txie_d, mstr_d, cpol_d, fen_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [BUS_W-1:0]  txbuf_q, txbuf_d, rxbuf_q, rxbuf_d;
  logic [1:0]        ss_sync_q;

  logic wr_c1, wr_c2, wr_bd, rd_st, rd_dt, wr_dt;
  logic master_run, fault, start, busy, xfer_done, tick, tx_accept;
  logic spif_w, sptef_w, modf_w, sck_w, mosi_w;
  logic [BUS_W-1:0] rx_byte;

  always_comb begin
    wr_c1 = bus_wr && (bus_addr == ADDR_CTRL1);
    wr_c2 = bus_wr && (bus_addr == ADDR_CTRL2);
    wr_bd = bus_wr && (bus_addr == ADDR_BAUD);
    wr_dt = bus_wr && (bus_addr == ADDR_DATA);
    rd_st = bus_rd && (bus_addr == ADDR_STAT);
    rd_dt = bus_rd && (bus_addr == ADDR_DATA);
    master_run = en_q && mstr_q;
    fault      = master_run && ctrl2_fen_q && !ss_sync_q[1];
    start      = master_run && !busy && !sptef_w && !fault;
  end

  // next-state of the software-visible registers
  always_comb begin
    rxie_d = rxie_q; en_d = en_q; txie_d = txie_q; mstr_d = mstr_q; cpol_d = cpol_q;
    if (wr_c1) begin
      rxie_d = bus_wdata[C1_RXIE];
      en_d   = bus_wdata[C1_EN];
      txie_d = bus_wdata[C1_TXIE];
      mstr_d = bus_wdata[C1_MSTR];
      cpol_d = bus_wdata[C1_CPOL];
    end
    if (fault) mstr_d = 1'b0;
    fen_d   = wr_c2 ? bus_wdata[C2_FEN] : ctrl2_fen_q;
    pre_d   = wr_bd ? bus_wdata[PRE_LSB +: PRE_W] : pre_q;
    rate_d  = wr_bd ? bus_wdata[RATE_W-1:0] : rate_q;
    txbuf_d = tx_accept ? bus_wdata : txbuf_q;
    rxbuf_d = xfer_done ? rx_byte : rxbuf_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rxie_q <= 1'b0; en_q <= 1'b0; txie_q <= 1'b0; mstr_q <= 1'b0; cpol_q <= 1'b0;
      ctrl2_fen_q <= 1'b0;
      pre_q   <= '0;
      rate_q  <= '0;
      txbuf_q <= '0;
      rxbuf_q <= '0;
      ss_sync_q <= 2'b11;
    end else begin
      rxie_q <= rxie_d; en_q <= en_d; txie_q <= txie_d; mstr_q <= mstr_d; cpol_q <= cpol_d;
      ctrl2_fen_q <= fen_d;
      pre_q   <= pre_d;
      rate_q  <= rate_d;
      txbuf_q <= txbuf_d;
      rxbuf_q <= rxbuf_d;
      ss_sync_q <= {ss_sync_q[0], ss_n_i};
    end
  end

  spi_baud_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) baud_i (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .pre(pre_q), .rate(rate_q), .tick(tick)
  );

  spi_shifter #(.DATA_W(BUS_W)) shift_i (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .abort(fault), .tick(tick),
    .cpol(cpol_q), .tx_byte(txbuf_q), .miso(miso_i), .busy(busy), .done(xfer_done),
    .rx_byte(rx_byte), .sck(sck_w), .mosi(mosi_w)
  );

  spi_flag_ctrl flags_i (
    .clk(clk), .rst_n(rst_sync_n), .stat_rd(rd_st), .data_rd(rd_dt), .data_wr(wr_dt),
    .ctrl1_wr(wr_c1), .xfer_done(xfer_done), .buf_load(start), .fault(fault),
    .spif(spif_w), .sptef(sptef_w), .modf(modf_w), .tx_accept(tx_accept)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADDR_CTRL1: begin
          bus_rdata[C1_RXIE] = rxie_q;
          bus_rdata[C1_EN]   = en_q;
          bus_rdata[C1_TXIE] = txie_q;
          bus_rdata[C1_MSTR] = mstr_q;
          bus_rdata[C1_CPOL] = cpol_q;
        end
        ADDR_CTRL2: bus_rdata[C2_FEN] = ctrl2_fen_q;
        ADDR_BAUD: begin
          bus_rdata[PRE_LSB +: PRE_W] = pre_q;
          bus_rdata[RATE_W-1:0]       = rate_q;
        end
        ADDR_STAT: begin
          bus_rdata[ST_RXF] = spif_w;
          bus_rdata[ST_TXE] = sptef_w;
          bus_rdata[ST_FLT] = modf_w;
        end
        ADDR_DATA: bus_rdata = rxbuf_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq     = (rxie_q && (spif_w || modf_w)) || (txie_q && sptef_w);
  assign sck_o   = sck_w;
  assign mosi_o  = mosi_w;
  assign sck_oe  = master_run;
  assign mosi_oe = master_run;
  assign ss_n_o  = !(master_run && busy);
endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       sck_oe,
  input logic       ss_n_o,
  input logic       spif,
  input logic       sptef,
  input logic       modf,
  input logic       fen
);
  assert_status_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3) |-> (bus_rdata[6] == 1'b0 && bus_rdata[3:0] == 4'd0));

  assert_select_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_o |-> sck_oe);

  assert_spif_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spif) |-> $past(bus_rd && bus_addr == 3'd5));

  assert_sptef_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sptef) |-> $past(bus_wr && bus_addr == 3'd5));

  assert_modf_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> $past(fen));

  assert_fault_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !sck_oe);

  assert_modf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf) |-> $past(bus_wr && bus_addr == 3'd0));
endmodule

bind spi_xfer_engine spi_xfer_checker chk_i (
  .clk(clk), .rst_n(rst_sync_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sck_oe(sck_oe), .ss_n_o(ss_n_o), .spif(spif_w),
  .sptef(sptef_w), .modf(modf_w), .fen(ctrl2_fen_q)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_i, ss_n_o;
  logic ss_n_i = 1'b1;

  int checks = 0, errors = 0, cyc = 0, ss_falls = 0;
  bit done_flag = 0;

  // behavioural slave on the far end of the link
  logic [7:0] slv_out = 8'h00, slv_sr = 8'h00, slv_in = 8'h00;
  bit cpol_b = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  always @(negedge ss_n_o) begin ss_falls++; slv_sr = slv_out; end
  always @(sck_o) if (ss_n_o === 1'b0) begin
    if (sck_o != cpol_b) slv_in = {slv_in[6:0], mosi_o};
    else                 slv_sr = {slv_sr[6:0], 1'b0};
  end
  assign miso_i = slv_sr[7];

  spi_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .ss_n_i(ss_n_i), .ss_n_o(ss_n_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic int divisor(input logic [7:0] b);
    return (int'(b[6:4]) + 1) * (2 << b[2:0]);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one full byte exchange with the slave, checking period, data and flags
  task automatic run_xfer(input logic [7:0] baud, input logic [7:0] mo, input logic [7:0] so,
                          input bit arm_first, input bit irq_exp);
    logic [7:0] r;
    int t1, t2;
    bus_write(3'd2, baud);
    slv_out = so;
    bus_read(3'd3, r);
    bus_write(3'd5, mo);
    @(posedge sck_o); t1 = cyc;
    @(posedge sck_o); t2 = cyc;
    chk("R3 sck period", t2 - t1, divisor(baud));
    @(posedge ss_n_o);
    repeat (3) @(negedge clk);
    chk("R10 irq after byte", irq, irq_exp);
    if (!arm_first) begin
      bus_read(3'd5, r);
      bus_read(3'd3, r);
      chk("R5 data read without status read keeps flag", r, 8'hA0);
    end else begin
      bus_read(3'd3, r);
      chk("R5 flag set after byte", r, 8'hA0);
    end
    bus_read(3'd5, r);
    chk("R4 received byte", r, so);
    chk("R4 byte seen by slave", slv_in, mo);
    bus_read(3'd3, r);
    chk("R5 flag cleared by read pair", r, 8'h20);
    chk("R10 irq after clear", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 sck_oe at reset", sck_oe, 0);
    chk("R1 mosi_oe at reset", mosi_oe, 0);
    chk("R1 ss_n_o at reset", ss_n_o, 1);
    chk("R1 irq at reset", irq, 0);
    bus_read(3'd0, r);
    chk("R1 ctrl1 at reset", r, 8'h00);

    // R6: data write before any status read is dropped
    bus_write(3'd2, 8'h00);
    bus_write(3'd0, 8'h50);
    bus_write(3'd5, 8'hC3);
    repeat (40) @(negedge clk);
    chk("R6 unarmed write starts nothing", ss_falls, 0);
    bus_read(3'd3, r);
    chk("R1 R6 status after reset and dropped write", r, 8'h20);

    bus_write(3'd3, 8'hFF);
    bus_read(3'd3, r);
    chk("R2 status write ignored", r, 8'h20);

    run_xfer(8'h00, 8'hA5, 8'h3C, 1, 0);
    chk("R6 one transfer for one armed write", ss_falls, 1);
    run_xfer(8'h12, 8'h81, 8'h7E, 0, 0);
    run_xfer(8'h70, 8'h0F, 8'hF0, 1, 0);
    run_xfer(8'h67, 8'h96, 8'h69, 1, 0);

    bus_write(3'd0, 8'h70);
    @(negedge clk);
    chk("R10 irq from empty buffer", irq, 1);
    bus_write(3'd0, 8'hD0);
    @(negedge clk);
    chk("R10 irq idle with rx enable", irq, 0);
    run_xfer(8'h01, 8'h5A, 8'hC6, 1, 1);

    cpol_b = 1;
    bus_write(3'd0, 8'h58);
    repeat (2) @(negedge clk);
    chk("R11 idle clock high", sck_o, 1);
    run_xfer(8'h11, 8'hE7, 8'h18, 1, 0);
    chk("R11 idle clock high after byte", sck_o, 1);
    cpol_b = 0;
    bus_write(3'd0, 8'h50);

    // R7: low select with detection off
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    bus_read(3'd3, r);
    chk("R7 no fault with detection off", r, 8'h20);
    chk("R7 still driving", sck_oe, 1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R8/R9: fault in the middle of a slow byte
    bus_write(3'd1, 8'h10);
    bus_write(3'd2, 8'h77);
    bus_read(3'd3, r);
    bus_write(3'd5, 8'h33);
    repeat (200) @(negedge clk);
    chk("R8 transfer running before fault", ss_n_o, 0);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 sck released", sck_oe, 0);
    chk("R8 mosi released", mosi_oe, 0);
    chk("R8 select raised", ss_n_o, 1);
    bus_read(3'd0, r);
    chk("R8 master bit cleared", r, 8'h40);
    ss_n_i = 1'b1;
    bus_write(3'd0, 8'h40);
    repeat (17000) @(negedge clk);
    bus_read(3'd3, r);
    chk("R9 R8 fault held, no rx flag", r, 8'h30);
    bus_write(3'd0, 8'h50);
    @(negedge clk);
    bus_read(3'd3, r);
    chk("R9 fault cleared by read pair", r, 8'h20);
    chk("R9 driving again", sck_oe, 1);

    finish_run();
  end
endmodule